// File: doc/BRIEF.md
# Audio DAC Transmit FIFO Controller

This block buffers playback samples between a DMA engine and a stereo DAC sample port. A bus master (a DMA channel or software) writes raw sample words to a data register. Each word is widened to a 24-bit sample as it enters a 64-entry FIFO. On each sample strobe from the DAC side, the block hands over one left/right frame. It raises a DMA request while enough room is free, and hysteresis keeps that request from toggling on every write.

A single control register sets the behaviour. It holds a flush command, a request enable, a trigger level and a cut-off code for the request, a mono or stereo layout, the input width, a widening mode for 16-bit data, and a policy for what the DAC sees when the FIFO runs dry. A status register reports the free space and two sticky error flags. A counter reports how many frames have been delivered.

Top module: `dac_txfifo`

## Requirements
- R1: After reset, status reads 0x40 (64 free entries, no flags), control and the frame counter read 0, `dma_req` is 0 and both channel outputs are 0.
- R2: The registers are 32 bits wide at byte offsets 0x04 (control), 0x08 (status), 0x0C (data, write only, reads 0) and 0x30 (frame counter, read only). Control reads back as written, except that bit 0 reads 0 from the second cycle after the write.
- R3: A data write while 64 entries are held is dropped and sets status bit 9. Writing 1 to status bit 9 clears it.
- R4: A control write with bit 0 set empties the FIFO at the edge of the write and loads the other control bits from the same write.
- R5: With control bit 5 = 0 and bit 24 = 0, a sample is data bits [15:0] followed by eight zero bits.
- R6: With control bit 5 = 0 and bit 24 = 1, a sample is data bits [15:0] followed by eight copies of data bit 15.
- R7: With control bit 5 = 1, a sample is data bits [31:8].
- R8: In stereo mode (control bit 6 = 0), a strobe with at least two entries held pops two entries: the older one goes to the left channel and the newer one to the right.
- R9: In mono mode (control bit 6 = 1), a strobe with at least one entry held pops one entry and sends it to both channels.
- R10: A strobe with too few entries (none in mono, fewer than two in stereo) pops nothing and sets status bit 8; writing 1 to status bit 8 clears it. The outputs go to 0 when control bit 26 = 0 and keep the last frame when it is 1.
- R11: While control bit 4 is set, `dma_req` rises when the free count exceeds control bits [13:8]. It then stays high until the free count falls below 2 shifted left by control bits [22:21] (code 3 gives 16). Clearing bit 4 drops `dma_req` at the edge of that write.
- R12: The frame counter increments once for each frame delivered from the FIFO and does not increment on underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| smp_strobe | input | 1 | DAC frame request |
| dma_req | output | 1 | DMA request |
| left_out | output | 24 | Left channel sample |
| right_out | output | 24 | Right channel sample |

## Verification
Register reads are combinational, so status, control and counter values are valid one edge after the write or strobe that changes them. The channel outputs also change at the strobe edge. `dma_req` is registered, so it follows a change in the free count one further edge later. Every bench action therefore spans two edges and samples at the falling edge after the second one, while the request model in the bench is stepped once per action. The one exception is the enable-clear check, which samples `dma_req` at the falling edge just after the write edge.

// File: rtl/dac_txfifo.sv
module dac_txfifo #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        smp_strobe,
  output logic        dma_req,
  output logic [23:0] left_out,
  output logic [23:0] right_out
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [7:0] A_CTRL = 8'h04, A_STAT = 8'h08, A_DATA = 8'h0C, A_CNT = 8'h30;

  logic [31:0]   ctrl, frames;
  logic [23:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          unr, ovr, req_q;

  wire req_en   = ctrl[4];
  wire wide     = ctrl[5];
  wire mono     = ctrl[6];
  wire msb_fill = ctrl[24];
  wire hold     = ctrl[26];

  wire [7:0] free = 8'(DEPTH) - 8'(cnt);
  wire [7:0] thr  = 8'd2 << ctrl[22:21];
  wire [7:0] trig = {2'b00, ctrl[13:8]};

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire flush   = wr_ctrl && bus_wdata[0];
  wire full    = cnt == CW'(DEPTH);
  wire push    = wr_data && !full;

  wire [23:0] fmt = wide ? bus_wdata[31:8]
                         : {bus_wdata[15:0], msb_fill ? {8{bus_wdata[15]}} : 8'h00};

  wire [CW-1:0] need  = mono ? CW'(1) : CW'(2);
  wire          avail = cnt >= need;
  wire          take  = smp_strobe && avail;
  wire [CW-1:0] pops  = take ? need : '0;

  always_ff @(posedge clk)
    if (push) mem[wp] <= fmt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; frames <= '0; wp <= '0; rp <= '0; cnt <= '0;
      unr <= 1'b0; ovr <= 1'b0; req_q <= 1'b0;
      left_out <= '0; right_out <= '0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata;
      else         ctrl[0] <= 1'b0;

      if (flush) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (push) wp <= wp + AW'(1);
        rp  <= rp + AW'(pops);
        cnt <= cnt + CW'(push) - pops;
      end

      unr <= (smp_strobe && !avail) || (unr && !(wr_stat && bus_wdata[8]));
      ovr <= (wr_data && full)      || (ovr && !(wr_stat && bus_wdata[9]));

      if (take) begin
        left_out  <= mem[rp];
        right_out <= mono ? mem[rp] : mem[rp + AW'(1)];
        frames    <= frames + 32'd1;
      end else if (smp_strobe && !hold) begin
        left_out  <= '0;
        right_out <= '0;
      end

      req_q <= req_en && (req_q ? free >= thr : free > trig);
    end
  end

  assign dma_req = req_q && req_en;

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_STAT:  bus_rdata = {22'd0, ovr, unr, free};
      A_CNT:   bus_rdata = frames;
      default: bus_rdata = '0;
    endcase

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && full) |=> (ovr && cnt == CW'(DEPTH)));
  a_r4_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0 && !ctrl[0] == 1'b0));
  a_r9_mono_same: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_strobe && mono && cnt != '0) |=> left_out == right_out);
  a_r10_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_strobe && cnt == '0) |=> (unr && $stable(cnt)));
  a_r11_req_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(free > trig));
endmodule

// File: tb/dac_txfifo_test.sv
module dac_txfifo_test;
  logic clk = 0, rst_n = 0, bus_wr = 0, smp_strobe = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic dma_req;
  logic [23:0] left_out, right_out;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  localparam logic [7:0] CT = 8'h04, ST = 8'h08, DT = 8'h0C, CN = 8'h30;

  dac_txfifo uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic strobe();
    @(negedge clk); smp_strobe = 1;
    @(negedge clk); smp_strobe = 0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] word(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ (i << 15);
  endfunction

  initial begin
    #3_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, e;
    logic [23:0] a_s, b_s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(ST, r); chk("R1 status", r, 32'h40);
    rd(CT, r); chk("R1 ctrl", r, 0);
    rd(CN, r); chk("R1 counter", r, 0);
    chk("R1 dma_req", {31'd0, dma_req}, 0);
    chk("R1 left", {8'd0, left_out}, 0);
    chk("R1 right", {8'd0, right_out}, 0);

    wr(CT, 32'h0460_0F60); rd(CT, r); chk("R2 ctrl readback", r, 32'h0460_0F60);
    rd(DT, r); chk("R2 data reads zero", r, 0);
    wr(CT, 32'h0000_0041); rd(CT, r); chk("R2 flush self-clears", r, 32'h40);

    for (int m = 0; m < 3; m++) begin
      wr(CT, 32'h41 | (m == 2 ? 32'h20 : 0) | (m == 1 ? 32'h0100_0000 : 0));
      for (int i = 0; i < 64; i++) begin
        logic [31:0] d;
        d = word(i + 64 * m);
        wr(DT, d);
        strobe();
        if (m == 0)      e = (d & 32'hFFFF) << 8;
        else if (m == 1) e = ((d & 32'hFFFF) << 8) | (d[15] ? 32'hFF : 0);
        else             e = (d >> 8) & 32'hFF_FFFF;
        chk(m == 0 ? "R5 zero pad left" : m == 1 ? "R6 msb fill left" : "R7 wide left",
            {8'd0, left_out}, e);
        chk("R9 mono right", {8'd0, right_out}, e);
      end
    end
    rd(CN, r); chk("R12 frame count", r, 192);

    wr(CT, 32'h1);
    for (int i = 0; i < 8; i++) wr(DT, 32'h1000 * (i + 1) + i);
    for (int k = 0; k < 4; k++) begin
      strobe();
      chk("R8 stereo left",  {8'd0, left_out},  (32'h1000 * (2 * k + 1) + 2 * k) << 8);
      chk("R8 stereo right", {8'd0, right_out}, (32'h1000 * (2 * k + 2) + 2 * k + 1) << 8);
    end
    rd(CN, r); chk("R12 stereo frames", r, 196);

    wr(DT, 32'h0000_1234);
    strobe();
    chk("R10 zero left", {8'd0, left_out}, 0);
    chk("R10 zero right", {8'd0, right_out}, 0);
    rd(ST, r); chk("R10 flag, nothing popped", r, 32'h13F);
    rd(CN, r); chk("R12 no count on underrun", r, 196);
    wr(ST, 32'h100); rd(ST, r); chk("R10 flag cleared", r, 32'h3F);
    wr(CT, 32'h0400_0000);
    wr(DT, 32'h0000_8765);
    strobe();
    a_s = 24'h123400; b_s = 24'h876500;
    chk("R8 pair left", {8'd0, left_out}, {8'd0, a_s});
    strobe();
    chk("R10 hold left", {8'd0, left_out}, {8'd0, a_s});
    chk("R10 hold right", {8'd0, right_out}, {8'd0, b_s});
    rd(ST, r); chk("R10 flag again", r, 32'h140);

    wr(CT, 32'h41);
    for (int i = 0; i < 64; i++) wr(DT, 32'h100 + i);
    rd(ST, r); chk("R3 full", r & 32'h2FF, 0);
    wr(DT, 32'hDEAD);
    rd(ST, r); chk("R3 overrun flag", r & 32'h2FF, 32'h200);
    strobe();
    chk("R3 oldest kept", {8'd0, left_out}, 32'h100 << 8);
    wr(ST, 32'h300); rd(ST, r); chk("R3 flags cleared", r, 32'h1);
    wr(CT, 32'h0500_0061); rd(ST, r); chk("R4 flush empties", r, 32'h40);
    rd(CT, r); chk("R4 other fields kept", r, 32'h0500_0060);

    for (int v = 0; v < 5; v++) begin
      int trig, code, thr, fr;
      bit req;
      trig = (v == 4) ? 40 : 15;
      code = (v == 4) ? 1 : v;
      thr = 2 << code;
      wr(CT, 0);
      wr(CT, 32'h51 | (trig << 8) | (code << 21));
      fr = 64; req = 0;
      req = req ? fr >= thr : fr > trig;
      chk("R11 initial req", {31'd0, dma_req}, {31'd0, req});
      for (int i = 0; i < 60; i++) begin
        wr(DT, i); fr--;
        req = req ? fr >= thr : fr > trig;
        chk("R11 req on fill", {31'd0, dma_req}, {31'd0, req});
      end
      for (int i = 0; i < 60; i++) begin
        strobe(); fr++;
        req = req ? fr >= thr : fr > trig;
        chk("R11 req on drain", {31'd0, dma_req}, {31'd0, req});
      end
    end
    @(negedge clk); bus_addr = CT; bus_wdata = 32'h40; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    chk("R11 disable drops at once", {31'd0, dma_req}, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule